// File: doc/BRIEF.md
# Debug Entry Controller

This block is the control state machine of a small in-order processor pipeline. It handles the paths that pull the pipeline away from normal decoding: exceptions, sleep on a wait-for-interrupt instruction, entry into debug mode, and return from it. Debug mode can be entered in four ways: an external halt request, a single-step request once one instruction has completed, a breakpoint instruction, or a match on the single instruction-address trigger. On entry the block writes the debug return address. Which address is written depends on the cause. For a breakpoint it is the address of the breakpoint instruction. When a stepped instruction faults it is the trap handler address. In every other case it is the next fetch address.

Two timing rules shape the block. First, the decision to enter debug mode is captured when the machine leaves the decode state, and the flush state acts only on that captured decision. As a result, a wait-for-interrupt instruction that is already flushing still goes to sleep when a halt request appears late, and the halt then wakes the core. Second, the busy signal used for the core clock gate comes straight from a flop.

The debug program memory and the control-register storage sit outside the block. It only supplies the return address, the write strobe for it, and the fetch redirect selection.

Top module: `dbgctl_top`

## Requirements
- R1: After reset the block is in the first-fetch state with stall_id_o=0, flush_o=0, pc_sel_o=00, dpc_we_o=0, sleep_o=0, dbg_mode_o=0 and busy_q_o=1. It moves to decode on the first cycle that instr_valid_i is 1.
- R2: In decode, a valid exception (exc_i, or a breakpoint with dbg_on_ebrk_i=0 outside debug mode) or a valid WFI leads to exactly one flush cycle with flush_o=1. For an exception that cycle has pc_sel_o=01 (trap vector), and with no debug request captured the machine returns to decode.
- R3: The debug-entry request is captured when decode is left. A flush caused by a WFI with no captured request goes to the sleep state (sleep_o=1), even if halt_req_i rises during the flush. Sleep returns to first-fetch when irq_i or halt_req_i is 1.
- R4: A valid breakpoint with dbg_on_ebrk_i=1, in the same cycle as a halt or step request, takes the breakpoint path. The return address written is the decode PC.
- R5: While a debug entry (halt, trigger, step or breakpoint entry) is pending in decode and wb_busy_i=1, stall_id_o=1 and the state does not advance.
- R6: When a single-stepped instruction raises an exception, the flush cycle shows pc_sel_o=01, and the following debug entry writes trap_pc_i as the return address.
- R7: With the trigger built in and trig_en_i=1, a fetch PC equal to trig_addr_i in decode, outside debug mode, enters debug mode with the return address set to that fetch PC.
- R8: busy_q_o is 0 exactly in the cycle after a cycle spent in the sleep state, and 1 otherwise.
- R9: In debug mode, halt_req_i, the trigger and step_en_i have no effect. A valid dret_i in debug mode gives flush_o=1 and pc_sel_o=11 (return from debug) in that cycle, and debug mode is left.
- R10: A debug-entry cycle has flush_o=1, pc_sel_o=10 (debug entry) and dpc_we_o=1. The one exception is a breakpoint taken inside debug mode, which does not write. dbg_mode_o is 1 from the next cycle.
- R11: A halt request, or step completion without a breakpoint or exception, enters debug mode with the return address set to the fetch PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Decode stage holds a valid instruction |
| halt_req_i | input | 1 | External debug halt request |
| step_en_i | input | 1 | Single-step enable |
| ebrk_i | input | 1 | Decoded instruction is a breakpoint |
| dbg_on_ebrk_i | input | 1 | Breakpoints enter debug mode |
| wfi_i | input | 1 | Decoded instruction is wait-for-interrupt |
| exc_i | input | 1 | Decoded instruction raises an exception |
| dret_i | input | 1 | Decoded instruction returns from debug |
| wb_busy_i | input | 1 | Writeback stage holds an unfinished instruction |
| irq_i | input | 1 | Pending enabled interrupt (wakes sleep) |
| pc_if_i | input | ADDR_W | Fetch-stage PC |
| pc_id_i | input | ADDR_W | Decode-stage PC |
| trap_pc_i | input | ADDR_W | Exception handler address |
| trig_en_i | input | 1 | Trigger armed |
| trig_addr_i | input | ADDR_W | Trigger match address |
| stall_id_o | output | 1 | Hold decode stage |
| flush_o | output | 1 | Flush pipeline |
| pc_sel_o | output | 2 | 00 none, 01 trap, 10 debug entry, 11 debug return |
| dpc_we_o | output | 1 | Return-address write strobe |
| dpc_o | output | ADDR_W | Return-address value |
| sleep_o | output | 1 | Core is asleep |
| busy_q_o | output | 1 | Registered busy for the clock gate |
| dbg_mode_o | output | 1 | Core is in debug mode |

## Verification
The bench builds the block with ADDR_W=12 and the trigger variant enabled (TRIG_EN=1). Random fetch PCs are drawn from a 16-address window around a fixed trigger address, so trigger matches happen often, and they coincide with halts, steps, breakpoints and writeback stalls. The narrow address width keeps the return-address values short and easy to read, and it still exercises every mux source feeding the captured address.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;

   typedef enum logic [2:0] {
      ST_BOOTFETCH = 3'd0,
      ST_DECODE    = 3'd1,
      ST_FLUSH     = 3'd2,
      ST_SLEEP     = 3'd3,
      ST_DBG_FPC   = 3'd4,
      ST_DBG_DPC   = 3'd5
   } ctl_state_e;

   typedef enum logic [1:0] {
      PCS_NONE  = 2'b00,
      PCS_TRAP  = 2'b01,
      PCS_DENTR = 2'b10,
      PCS_DRET  = 2'b11
   } pc_sel_e;

endpackage

// File: rtl/dbgctl_trig.sv
module dbgctl_trig #(
   parameter int unsigned ADDR_W  = 32,
   parameter bit          TRIG_EN = 1'b1
) (
   input  logic              en_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);

   generate
      if (TRIG_EN) begin : g_trig
         assign hit_o = en_i && (pc_i == addr_i);
      end else begin : g_no_trig
         logic unused_trig;
         assign unused_trig = ^{en_i, pc_i, addr_i};
         assign hit_o       = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dbgctl_busy.sv
module dbgctl_busy (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic idle_i,
   output logic busy_q_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) busy_q_o <= 1'b1;
      else         busy_q_o <= !idle_i;
   end

   // R8: a sleeping cycle closes the gate on the next cycle
   assert_busy_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_i |=> !busy_q_o);
   assert_busy_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !idle_i |=> busy_q_o);

endmodule

// File: rtl/dbgctl_fsm.sv
module dbgctl_fsm
   import dbgctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              instr_valid_i,
   input  logic              halt_req_i,
   input  logic              step_en_i,
   input  logic              ebrk_i,
   input  logic              dbg_on_ebrk_i,
   input  logic              wfi_i,
   input  logic              exc_i,
   input  logic              dret_i,
   input  logic              wb_busy_i,
   input  logic              irq_i,
   input  logic              trig_hit_i,
   input  logic [ADDR_W-1:0] pc_if_i,
   input  logic [ADDR_W-1:0] pc_id_i,
   input  logic [ADDR_W-1:0] trap_pc_i,
   output logic              stall_id_o,
   output logic              flush_o,
   output logic [1:0]        pc_sel_o,
   output logic              dpc_we_o,
   output logic [ADDR_W-1:0] dpc_o,
   output logic              sleep_o,
   output logic              dbg_mode_o
);

   ctl_state_e        state_q, state_d;
   logic              dbg_mode_q, dbg_mode_d;
   logic              dreq_q, dreq_d;   // captured debug decision
   logic              exc_q, exc_d;     // flush cause is an exception
   logic [ADDR_W-1:0] dpc_q, dpc_d;
   pc_sel_e           pc_sel;

   // decode-stage qualifiers
   logic exc_go, ebrk_go, wfi_go, dret_go, dbg_req, entry_pend;

   assign exc_go     = instr_valid_i &&
                       (exc_i || (ebrk_i && !dbg_on_ebrk_i && !dbg_mode_q));
   assign ebrk_go    = instr_valid_i && ebrk_i && !exc_i &&
                       (dbg_on_ebrk_i || dbg_mode_q);
   assign wfi_go     = instr_valid_i && wfi_i && !dbg_mode_q;
   assign dret_go    = instr_valid_i && dret_i && dbg_mode_q;
   assign dbg_req    = !dbg_mode_q &&
                       (halt_req_i || trig_hit_i || (step_en_i && instr_valid_i));
   assign entry_pend = dbg_req || ebrk_go;

   always_comb begin
      state_d    = state_q;
      dbg_mode_d = dbg_mode_q;
      dreq_d     = dreq_q;
      exc_d      = exc_q;
      dpc_d      = dpc_q;
      stall_id_o = 1'b0;
      flush_o    = 1'b0;
      pc_sel     = PCS_NONE;
      dpc_we_o   = 1'b0;
      sleep_o    = 1'b0;

      unique case (state_q)
         ST_BOOTFETCH: begin
            if (instr_valid_i) state_d = ST_DECODE;
         end

         ST_DECODE: begin
            stall_id_o = entry_pend && wb_busy_i;
            if (!stall_id_o) begin
               if (ebrk_go)     dpc_d = pc_id_i;
               else if (exc_go) dpc_d = trap_pc_i;
               else             dpc_d = pc_if_i;

               if (exc_go) begin
                  state_d = ST_FLUSH;
                  dreq_d  = dbg_req;
                  exc_d   = 1'b1;
               end else if (ebrk_go) begin
                  state_d = ST_DBG_DPC;
               end else if (wfi_go) begin
                  state_d = ST_FLUSH;
                  dreq_d  = dbg_req;
                  exc_d   = 1'b0;
               end else if (dret_go) begin
                  flush_o    = 1'b1;
                  pc_sel     = PCS_DRET;
                  dbg_mode_d = 1'b0;
               end else if (dbg_req) begin
                  state_d = ST_DBG_FPC;
               end
            end
         end

         ST_FLUSH: begin
            flush_o = 1'b1;
            if (exc_q) pc_sel = PCS_TRAP;
            if (dreq_q)     state_d = ST_DBG_FPC;
            else if (exc_q) state_d = ST_DECODE;
            else            state_d = ST_SLEEP;
         end

         ST_SLEEP: begin
            sleep_o = 1'b1;
            if (irq_i || halt_req_i) state_d = ST_BOOTFETCH;
         end

         ST_DBG_FPC: begin
            flush_o    = 1'b1;
            pc_sel     = PCS_DENTR;
            dpc_we_o   = 1'b1;
            dbg_mode_d = 1'b1;
            state_d    = ST_DECODE;
         end

         ST_DBG_DPC: begin
            flush_o    = 1'b1;
            pc_sel     = PCS_DENTR;
            dpc_we_o   = !dbg_mode_q;
            dbg_mode_d = 1'b1;
            state_d    = ST_DECODE;
         end

         default: state_d = ST_BOOTFETCH;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_BOOTFETCH;
         dbg_mode_q <= 1'b0;
         dreq_q     <= 1'b0;
         exc_q      <= 1'b0;
         dpc_q      <= '0;
      end else begin
         state_q    <= state_d;
         dbg_mode_q <= dbg_mode_d;
         dreq_q     <= dreq_d;
         exc_q      <= exc_d;
         dpc_q      <= dpc_d;
      end
   end

   assign pc_sel_o   = pc_sel;
   assign dpc_o      = dpc_q;
   assign dbg_mode_o = dbg_mode_q;

   // R3: a WFI flush with no captured request always sleeps
   assert_wfi_sleeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_FLUSH && !exc_q && !dreq_q) |=> (state_q == ST_SLEEP));

   // R5: a stalled decode does not advance
   assert_stall_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_id_o |=> (state_q == ST_DECODE));

   // R6: a stepped exception keeps the handler address for the entry
   assert_step_exc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_FLUSH && exc_q && dreq_q) |=> (state_q == ST_DBG_FPC && $stable(dpc_q)));

   // R9: without a valid instruction, debug mode in decode is left untouched
   assert_dbg_ignores_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_DECODE && dbg_mode_q && !instr_valid_i)
      |=> (state_q == ST_DECODE && dbg_mode_q));

   // R10: any entry state leaves debug mode set
   assert_entry_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_DBG_FPC || state_q == ST_DBG_DPC) |=> dbg_mode_q);

endmodule

// File: rtl/dbgctl_top.sv
module dbgctl_top #(
   parameter int unsigned ADDR_W  = 32,
   parameter bit          TRIG_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              instr_valid_i,
   input  logic              halt_req_i,
   input  logic              step_en_i,
   input  logic              ebrk_i,
   input  logic              dbg_on_ebrk_i,
   input  logic              wfi_i,
   input  logic              exc_i,
   input  logic              dret_i,
   input  logic              wb_busy_i,
   input  logic              irq_i,
   input  logic [ADDR_W-1:0] pc_if_i,
   input  logic [ADDR_W-1:0] pc_id_i,
   input  logic [ADDR_W-1:0] trap_pc_i,
   input  logic              trig_en_i,
   input  logic [ADDR_W-1:0] trig_addr_i,
   output logic              stall_id_o,
   output logic              flush_o,
   output logic [1:0]        pc_sel_o,
   output logic              dpc_we_o,
   output logic [ADDR_W-1:0] dpc_o,
   output logic              sleep_o,
   output logic              busy_q_o,
   output logic              dbg_mode_o
);

   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
         $error("dbgctl_top: ADDR_W must lie in 8..64");
      end
   endgenerate

   logic trig_hit;

   dbgctl_trig #(
      .ADDR_W  (ADDR_W),
      .TRIG_EN (TRIG_EN)
   ) u_trig (
      .en_i   (trig_en_i),
      .pc_i   (pc_if_i),
      .addr_i (trig_addr_i),
      .hit_o  (trig_hit)
   );

   dbgctl_fsm #(
      .ADDR_W (ADDR_W)
   ) u_fsm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .instr_valid_i (instr_valid_i),
      .halt_req_i    (halt_req_i),
      .step_en_i     (step_en_i),
      .ebrk_i        (ebrk_i),
      .dbg_on_ebrk_i (dbg_on_ebrk_i),
      .wfi_i         (wfi_i),
      .exc_i         (exc_i),
      .dret_i        (dret_i),
      .wb_busy_i     (wb_busy_i),
      .irq_i         (irq_i),
      .trig_hit_i    (trig_hit),
      .pc_if_i       (pc_if_i),
      .pc_id_i       (pc_id_i),
      .trap_pc_i     (trap_pc_i),
      .stall_id_o    (stall_id_o),
      .flush_o       (flush_o),
      .pc_sel_o      (pc_sel_o),
      .dpc_we_o      (dpc_we_o),
      .dpc_o         (dpc_o),
      .sleep_o       (sleep_o),
      .dbg_mode_o    (dbg_mode_o)
   );

   dbgctl_busy u_busy (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .idle_i   (sleep_o),
      .busy_q_o (busy_q_o)
   );

endmodule

// File: tb/dbgctl_top_tb.sv
module dbgctl_top_tb_top;

   localparam int AW = 12;
   localparam int S_BOOT = 0, S_DEC = 1, S_FL = 2, S_SL = 3, S_DIF = 4, S_DID = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic iv, halt, step, ebrk, ebrk_en, wfi, exc, dret, wbb, irq, trig_en;
   logic [AW-1:0] pc_if, pc_id, trap, trig_addr;
   logic stall_o, flush_o, we_o, sleep_o, busy_o, dbg_o;
   logic [1:0] sel_o;
   logic [AW-1:0] dpc_o;

   dbgctl_top #(.ADDR_W(AW), .TRIG_EN(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(iv), .halt_req_i(halt),
      .step_en_i(step), .ebrk_i(ebrk), .dbg_on_ebrk_i(ebrk_en), .wfi_i(wfi),
      .exc_i(exc), .dret_i(dret), .wb_busy_i(wbb), .irq_i(irq),
      .pc_if_i(pc_if), .pc_id_i(pc_id), .trap_pc_i(trap),
      .trig_en_i(trig_en), .trig_addr_i(trig_addr),
      .stall_id_o(stall_o), .flush_o(flush_o), .pc_sel_o(sel_o),
      .dpc_we_o(we_o), .dpc_o(dpc_o), .sleep_o(sleep_o),
      .busy_q_o(busy_o), .dbg_mode_o(dbg_o));

   int checks = 0;
   int errors = 0;

   // reference model state
   int m_st, n_st;
   bit m_dbg, m_req, m_exc, m_busy;
   bit n_dbg, n_req, n_exc;
   logic [AW-1:0] m_dpc, n_dpc;
   bit e_stall, e_flush, e_we, e_sleep;
   logic [1:0] e_sel;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic void model();
      bit trg, exa, ebd, wfg, drg, dreq;
      e_stall = 0; e_flush = 0; e_sel = 2'b00; e_we = 0; e_sleep = 0;
      n_st = m_st; n_dbg = m_dbg; n_req = m_req; n_exc = m_exc; n_dpc = m_dpc;
      trg  = trig_en && (pc_if == trig_addr);
      exa  = iv && (exc || (ebrk && !ebrk_en && !m_dbg));
      ebd  = iv && ebrk && !exc && (ebrk_en || m_dbg);
      wfg  = iv && wfi && !m_dbg;
      drg  = iv && dret && m_dbg;
      dreq = !m_dbg && (halt || trg || (step && iv));
      case (m_st)
         S_BOOT: if (iv) n_st = S_DEC;
         S_DEC: begin
            e_stall = (dreq || ebd) && wbb;
            if (!e_stall) begin
               n_dpc = ebd ? pc_id : (exa ? trap : pc_if);
               if (exa) begin n_st = S_FL; n_req = dreq; n_exc = 1; end
               else if (ebd) n_st = S_DID;
               else if (wfg) begin n_st = S_FL; n_req = dreq; n_exc = 0; end
               else if (drg) begin e_flush = 1; e_sel = 2'b11; n_dbg = 0; end
               else if (dreq) n_st = S_DIF;
            end
         end
         S_FL: begin
            e_flush = 1;
            e_sel = m_exc ? 2'b01 : 2'b00;
            n_st = m_req ? S_DIF : (m_exc ? S_DEC : S_SL);
         end
         S_SL: begin
            e_sleep = 1;
            if (irq || halt) n_st = S_BOOT;
         end
         S_DIF: begin e_flush = 1; e_sel = 2'b10; e_we = 1; n_dbg = 1; n_st = S_DEC; end
         default: begin e_flush = 1; e_sel = 2'b10; e_we = !m_dbg; n_dbg = 1; n_st = S_DEC; end
      endcase
   endfunction

   task automatic clr();
      iv = 0; halt = 0; step = 0; ebrk = 0; ebrk_en = 0; wfi = 0; exc = 0;
      dret = 0; wbb = 0; irq = 0; trig_en = 0;
      pc_if = 12'h100; pc_id = 12'h0FC; trap = 12'h040; trig_addr = 12'h0AB;
   endtask

   // called at a falling edge with inputs already driven
   task automatic cyc();
      #1;
      model();
      chk("R5", "stall_id_o", stall_o, e_stall);
      chk("R2", "flush_o", flush_o, e_flush);
      chk("R2", "pc_sel_o", sel_o, e_sel);
      chk("R10", "dpc_we_o", we_o, e_we);
      if (e_we) chk("R11", "dpc_o", dpc_o, m_dpc);
      chk("R3", "sleep_o", sleep_o, e_sleep);
      chk("R8", "busy_q_o", busy_o, m_busy);
      chk("R9", "dbg_mode_o", dbg_o, m_dbg);
      @(posedge clk);
      m_busy = (m_st != S_SL);
      m_st = n_st; m_dbg = n_dbg; m_req = n_req; m_exc = n_exc; m_dpc = n_dpc;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      clr();
      m_st = S_BOOT; m_dbg = 0; m_req = 0; m_exc = 0; m_busy = 1; m_dpc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      #1;
      chk("R1", "stall", stall_o, 0); chk("R1", "flush", flush_o, 0);
      chk("R1", "pc_sel", sel_o, 0);  chk("R1", "dpc_we", we_o, 0);
      chk("R1", "sleep", sleep_o, 0); chk("R1", "dbg_mode", dbg_o, 0);
      chk("R1", "busy", busy_o, 1);
      cyc();
      iv = 1; cyc();                       // first-fetch -> decode

      // R3: WFI flush sleeps although halt rises during the flush
      clr(); iv = 1; wfi = 1; cyc();       // -> flush
      clr(); halt = 1; #1 chk("R3", "flush in wfi flush", flush_o, 1);
      cyc();                               // -> sleep
      #1 chk("R3", "sleep after wfi flush with late halt", sleep_o, 1);
      cyc();                               // halt wakes -> first-fetch
      #1 chk("R8", "busy after sleep", busy_o, 0);
      chk("R3", "woken", sleep_o, 0);
      iv = 1; cyc();                       // -> decode
      pc_if = 12'h3C0; cyc();              // halt -> entry via fetch pc
      clr(); #1;
      chk("R11", "halt dpc", dpc_o, 12'h3C0);
      chk("R10", "entry pc_sel", sel_o, 2'b10);
      chk("R10", "entry dpc_we", we_o, 1);
      cyc();
      #1 chk("R10", "debug mode set", dbg_o, 1);
      iv = 1; dret = 1; #1 chk("R9", "dret pc_sel", sel_o, 2'b11);
      cyc();
      clr(); #1 chk("R9", "dret leaves debug", dbg_o, 0);

      // R4: breakpoint together with halt uses decode pc
      iv = 1; ebrk = 1; ebrk_en = 1; halt = 1; pc_id = 12'h123; pc_if = 12'h456;
      cyc();
      clr(); #1;
      chk("R4", "ebreak dpc", dpc_o, 12'h123);
      chk("R4", "ebreak dpc_we", we_o, 1);
      cyc();
      iv = 1; dret = 1; cyc(); clr();

      // R6: step over a faulting instruction
      step = 1; iv = 1; exc = 1; trap = 12'h200; pc_if = 12'h077;
      cyc();
      clr(); step = 1; #1 chk("R6", "flush pc_sel trap", sel_o, 2'b01);
      cyc();
      #1 chk("R6", "step exception dpc", dpc_o, 12'h200);
      chk("R6", "step exception dpc_we", we_o, 1);
      cyc();
      step = 0; iv = 1; dret = 1; cyc(); clr();

      // R5: pending halt waits for writeback
      halt = 1; wbb = 1; #1 chk("R5", "stall with wb busy", stall_o, 1);
      cyc();
      #1 chk("R5", "still stalled", stall_o, 1);
      cyc();
      wbb = 0; #1 chk("R5", "stall released", stall_o, 0);
      cyc();
      clr(); cyc();
      iv = 1; dret = 1; cyc(); clr();

      // R7: trigger match, then R9: ignored in debug mode
      trig_en = 1; trig_addr = 12'h0AB; pc_if = 12'h0AB; cyc();
      #1 chk("R7", "trigger dpc", dpc_o, 12'h0AB);
      chk("R7", "trigger dpc_we", we_o, 1);
      cyc();
      halt = 1; #1 chk("R9", "no flush in debug", flush_o, 0);
      chk("R9", "no stall in debug", stall_o, 0);
      cyc();
      #1 chk("R9", "still debug, no entry", dbg_o, 1);
      chk("R9", "no entry strobe", we_o, 0);
      clr(); iv = 1; dret = 1; cyc(); clr();

      // random phase
      for (int i = 0; i < 4000; i++) begin
         iv      = ($urandom_range(0, 9) < 7);
         halt    = ($urandom_range(0, 19) == 0);
         step    = ($urandom_range(0, 7) == 0);
         ebrk    = ($urandom_range(0, 19) == 0);
         ebrk_en = $urandom_range(0, 1);
         wfi     = ($urandom_range(0, 19) == 0);
         exc     = ($urandom_range(0, 19) == 0);
         dret    = ($urandom_range(0, 5) == 0);
         wbb     = ($urandom_range(0, 9) < 3);
         irq     = ($urandom_range(0, 9) == 0);
         trig_en = $urandom_range(0, 1);
         pc_if   = 12'h0A0 + 12'($urandom_range(0, 15));
         pc_id   = 12'($urandom_range(0, 4095));
         trap    = 12'($urandom_range(0, 4095));
         trig_addr = 12'h0AB;
         cyc();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule